// File: doc/BRIEF.md
# Cascadable Slave Serial Result Port

This block sends a W-bit conversion result, most significant bit first, under a serial clock that comes from outside. The clock, the active-low chip select and the active-low read enable arrive without any relation to the fast system clock. Each one passes through a two-flop synchroniser, and the block finds the clock edges in the system clock domain. The data output is enabled only while chip select and read enable are both low. While either one is high, the output-enable is low and serial clock edges have no effect. A clock-invert input decides which serial clock edge moves the data out. The opposite edge captures a cascade input, so the results of several converters can be chained onto one data line.

The result register loads on the conversion-done strobe. A read may start after a conversion has finished, or it may start while the next conversion is still running. The level of the busy input when the read begins tells the two cases apart. A read that starts during a conversion does not use the cascade input. If a conversion finishes while a read is still in progress, the new result is dropped and the error output pulses for one system clock cycle.

A state machine tracks each read. ST_IDLE means no read is open. ST_READ means a read is open with fewer than W shift edges. ST_DONE means W shift edges have been counted and the cascaded data is still moving out. The transitions are START (ST_IDLE to ST_READ when the port becomes enabled), FINISH (ST_READ to ST_DONE on the W-th shift edge), RELEASE (ST_READ or ST_DONE to ST_IDLE when the enable drops) and RELOAD (ST_DONE to ST_IDLE when a new result loads).

Top module: `ser_daisy_port`

## Requirements
- R1: `sdout_oe` is 1 only when `cs_n` and `rd_n` were both 0 two system clocks earlier. Serial clock edges have no effect on the data while `sdout_oe` is 0.
- R2: Before the first shift edge of a read, `sdout` shows `result[W-1]`. Each shift edge moves out the next lower bit, so the bit seen before shift edge k+1 is `result[W-1-k]`.
- R3: With `clk_inv` = 0 the shift edge is the rising edge of `sclk_in`. With `clk_inv` = 1 it is the falling edge. The other edge is the capture edge.
- R4: In a read that starts with `conv_busy` = 0, the `sdin` value captured at the j-th capture edge appears on `sdout` after shift edge W+j-1. The first cascade bit therefore follows the local LSB directly.
- R5: In a read that starts with `conv_busy` = 1, `sdin` is ignored, and every bit after the local LSB is 0.
- R6: Capture edges that come before the first shift edge of a read are ignored. The serial clock may therefore idle at either level.
- R7: A `conv_done` strobe loads `result` into the shift register when no read is in ST_READ. `rd_err` stays 0.
- R8: A `conv_done` strobe while in ST_READ leaves the shift register unchanged and drives `rd_err` high for exactly one cycle. This includes the cycle in which the W-th shift edge is taken.
- R9: After reset, `sdout` = 0, `sdout_oe` = 0 and `rd_err` = 0.
- R10: A read ends (FINISH) after W shift edges. Dropping the enable part-way through (RELEASE) returns to ST_IDLE, so a following `conv_done` loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | External serial clock, asynchronous |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| rd_n | input | 1 | Active-low read enable, asynchronous |
| clk_inv | input | 1 | 0: shift on rising edge; 1: shift on falling edge |
| sdin | input | 1 | Cascade data from the upstream converter |
| conv_busy | input | 1 | High while a conversion is running (system clock domain) |
| conv_done | input | 1 | One-cycle strobe: a new result is ready |
| result | input | W | Conversion result to be sent |
| sdout | output | 1 | Serial data, MSB first |
| sdout_oe | output | 1 | Output-enable for the data line |
| rd_err | output | 1 | One-cycle pulse when a read is overrun by a new result |

## Verification
Two events can land in the same system cycle: the conversion-done strobe and the shift edge that completes a read. The bench times the strobe so that it coincides with the internal processing of the W-th shift edge, three system clocks after the serial clock toggles. It then expects an error pulse, and it expects the dropped result never to appear on a later read. The other case is a strobe that arrives in ST_IDLE while the enable is being asserted. Here the load must win, and the read that follows must carry the new word.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } rd_state_t;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int            N   = 4,
    parameter logic [N-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST[i];
                stab_q <= RST[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end

        assign q[i] = stab_q;
    end

endmodule

// File: rtl/ser_edge.sv
module ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic inv,
    output logic shift_p,
    output logic capt_p
);

    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        if (inv) begin
            shift_p = fall;
            capt_p  = rise;
        end else begin
            shift_p = rise;
            capt_p  = fall;
        end
    end

endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_port_pkg::*;
#(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          shift_p,
    input  logic          capt_p,
    input  logic          conv_done,
    input  logic          conv_busy,
    output logic          load,
    output logic          shift_do,
    output logic          capt_do,
    output logic          err,
    output rd_state_t     state,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(W - 1);

    rd_state_t st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic during_q;
    logic err_q;
    logic err_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs of the current state
    always_comb begin
        load     = 1'b0;
        err_set  = 1'b0;
        shift_do = 1'b0;
        capt_do  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                load = conv_done;
            end
            ST_READ: begin
                err_set  = conv_done;
                shift_do = en & shift_p;
                capt_do  = en & capt_p & ~during_q & (cnt_q != '0);
            end
            ST_DONE: begin
                load     = conv_done;
                shift_do = en & shift_p & ~conv_done;
                capt_do  = en & capt_p & ~during_q & ~conv_done;
            end
            default: ;
        endcase
    end

    // transitions: START, FINISH, RELEASE, RELOAD
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en) st_d = ST_READ;
            ST_READ: begin
                if (!en)                             st_d = ST_IDLE;
                else if (shift_do && cnt_q == LAST)  st_d = ST_DONE;
            end
            ST_DONE: begin
                if (!en || load) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            during_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= err_set;
            if (st_q == ST_IDLE) begin
                cnt_q <= '0;
                if (en) during_q <= conv_busy;
            end else if (st_q == ST_READ && shift_do) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign err   = err_q;
    assign state = st_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/ser_daisy_port.sv
module ser_daisy_port
    import ser_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_in,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         clk_inv,
    input  logic         sdin,
    input  logic         conv_busy,
    input  logic         conv_done,
    input  logic [W-1:0] result,
    output logic         sdout,
    output logic         sdout_oe,
    output logic         rd_err
);

    localparam int CW = $clog2(W + 1);

    logic [3:0]    raw;
    logic [3:0]    syn;
    logic          sclk_s, cs_s, rd_s, sdin_s;
    logic          en;
    logic          shift_p, capt_p;
    logic          load, shift_do, capt_do;
    rd_state_t     st;
    logic [CW-1:0] cnt;
    logic [W-1:0]  sr_q;

    assign raw = {sdin, rd_n, cs_n, sclk_in};

    ser_sync #(.N(4), .RST(4'b0110)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (syn)
    );

    assign sclk_s = syn[0];
    assign cs_s   = syn[1];
    assign rd_s   = syn[2];
    assign sdin_s = syn[3];
    assign en     = ~(cs_s | rd_s);

    ser_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (sclk_s),
        .inv     (clk_inv),
        .shift_p (shift_p),
        .capt_p  (capt_p)
    );

    ser_ctrl #(.W(W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .shift_p   (shift_p),
        .capt_p    (capt_p),
        .conv_done (conv_done),
        .conv_busy (conv_busy),
        .load      (load),
        .shift_do  (shift_do),
        .capt_do   (capt_do),
        .err       (rd_err),
        .state     (st),
        .cnt       (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= result;
        end else if (shift_do) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end else if (capt_do) begin
            sr_q[0] <= sdin_s;
        end
    end

    assign sdout    = sr_q[W-1];
    assign sdout_oe = en;

endmodule

// File: rtl/ser_daisy_port_chk.sv
module ser_daisy_port_chk
    import ser_port_pkg::*;
#(
    parameter int W  = 16,
    localparam int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          conv_done,
    input logic [W-1:0]  result,
    input logic          sdout_oe,
    input logic          rd_err,
    input logic          load,
    input logic          shift_do,
    input rd_state_t     st,
    input logic [CW-1:0] cnt,
    input logic [W-1:0]  sr_q
);

    p_oe_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sdout_oe |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));

    p_shift_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_do |-> sdout_oe);

    p_shift_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_do && !load) |=> (sr_q[W-1] == $past(sr_q[W-2])));

    p_load_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sr_q == $past(result)));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> ($past(st) == ST_READ && $past(conv_done)));

    p_no_load_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && conv_done) |-> !load);

    p_full_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> (cnt == CW'(W)));

endmodule

bind ser_daisy_port ser_daisy_port_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .conv_done (conv_done),
    .result    (result),
    .sdout_oe  (sdout_oe),
    .rd_err    (rd_err),
    .load      (load),
    .shift_do  (shift_do),
    .st        (st),
    .cnt       (cnt),
    .sr_q      (sr_q)
);

// File: tb/ser_daisy_port_tb_top.sv
module ser_daisy_port_tb_top;

    localparam int W = 16;
    localparam int H = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_in = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         clk_inv = 1'b0;
    logic         sdin = 1'b0;
    logic         conv_busy = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] result = '0;
    logic         sdout, sdout_oe, rd_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ser_daisy_port #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n(cs_n), .rd_n(rd_n),
        .clk_inv(clk_inv), .sdin(sdin), .conv_busy(conv_busy),
        .conv_done(conv_done), .result(result),
        .sdout(sdout), .sdout_oe(sdout_oe), .rd_err(rd_err)
    );

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_load(input logic [W-1:0] d);
        result = d; conv_done = 1'b1;
        nclk(1);
        conv_done = 1'b0;
        nclk(1);
        chk(rd_err, 1'b0, "R7 no error on idle load");
        chk(sdout, d[W-1], "R7 loaded MSB");
    endtask

    task automatic do_read(input logic [W-1:0] d, input logic [W-1:0] c,
                           input logic inv, input logic alt, input logic during,
                           input int inj, input logic coin, input int nbits);
        clk_inv = inv; conv_busy = during;
        sclk_in = alt ? ~inv : inv;
        sdin = 1'b1;
        nclk(6);
        cs_n = 1'b0; rd_n = 1'b0;
        nclk(6);
        chk(sdout_oe, 1'b1, "R1 enabled");
        if (alt) begin
            sclk_in = ~sclk_in;
            nclk(H);
        end
        for (int k = 0; k < nbits; k++) begin
            logic e;
            if (k < W) begin
                e = d[W-1-k];
                if (alt)      chk(sdout, e, "R6");
                else if (inv) chk(sdout, e, "R3");
                else          chk(sdout, e, "R2");
            end else begin
                e = during ? 1'b0 : c[W-1-(k-W)];
                if (during) chk(sdout, e, "R5");
                else        chk(sdout, e, "R4");
            end
            if (k == inj) begin
                conv_done = 1'b1; result = ~d;
                nclk(1);
                conv_done = 1'b0;
                chk(rd_err, 1'b1, "R8 overrun pulse");
                nclk(1);
                chk(rd_err, 1'b0, "R8 single cycle");
            end
            sclk_in = ~sclk_in;
            nclk(1);
            sdin = (k < W) ? c[W-1-k] : 1'b0;
            if (coin && k == W-1) begin
                nclk(1);
                conv_done = 1'b1; result = ~d;
                nclk(1);
                conv_done = 1'b0;
                chk(rd_err, 1'b1, "R8 coincident pulse");
                nclk(1);
                chk(rd_err, 1'b0, "R8 coincident single");
                nclk(H-4);
            end else begin
                nclk(H-1);
            end
            sclk_in = ~sclk_in;
            nclk(H);
        end
        cs_n = 1'b1; rd_n = 1'b1; conv_busy = 1'b0;
        nclk(4);
        chk(sdout_oe, 1'b0, "R1 released");
    endtask

    function automatic logic [W-1:0] pat(input int p);
        case (p)
            0: return 16'h8000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return W'((p * 16'h9E37) ^ 16'h5A5A);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        nclk(3);
        rst_n = 1'b1;
        nclk(3);
        chk(sdout, 1'b0, "R9 sdout");
        chk(sdout_oe, 1'b0, "R9 oe");
        chk(rd_err, 1'b0, "R9 err");

        // edges with only one enable low are ignored
        do_load(16'hA5C3);
        cs_n = 1'b1; rd_n = 1'b0;
        for (int i = 0; i < 10; i++) begin sclk_in = ~sclk_in; nclk(H); end
        chk(sdout_oe, 1'b0, "R1 cs high");
        cs_n = 1'b0; rd_n = 1'b1;
        for (int i = 0; i < 10; i++) begin sclk_in = ~sclk_in; nclk(H); end
        chk(sdout_oe, 1'b0, "R1 rd high");
        chk(sdout, 1'b1, "R1 data untouched");
        rd_n = 1'b1;
        do_read(16'hA5C3, 16'h0F0F, 1'b0, 1'b0, 1'b0, -1, 1'b0, 2*W);

        // sweep patterns, polarity and idle level
        for (int p = 0; p < 6; p++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int al = 0; al < 2; al++) begin
                    logic [W-1:0] d;
                    d = pat(p);
                    do_load(d);
                    do_read(d, {d[7:0], ~d[15:8]}, iv[0], al[0], 1'b0, -1, 1'b0, 2*W);
                end
            end
        end

        // read during conversion ignores cascade
        do_load(16'hC3A5);
        do_read(16'hC3A5, 16'hFFFF, 1'b0, 1'b0, 1'b1, -1, 1'b0, 2*W);

        // overrun mid-read
        do_load(16'h5A0F);
        do_read(16'h5A0F, 16'hFFFF, 1'b0, 1'b0, 1'b1, 5, 1'b0, 2*W);

        // strobe coincident with last shift edge; dropped word must not appear
        do_load(16'h9C63);
        do_read(16'h9C63, 16'hFFFF, 1'b1, 1'b0, 1'b1, -1, 1'b1, 2*W);
        do_read(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, -1, 1'b0, W);

        // release part-way, then load normally
        do_load(16'h1234);
        do_read(16'h1234, 16'h0000, 1'b0, 1'b0, 1'b0, -1, 1'b0, 4);
        result = 16'hBEEF; conv_done = 1'b1;
        nclk(1);
        conv_done = 1'b0;
        nclk(1);
        chk(rd_err, 1'b0, "R10 no error after release");
        chk(sdout, 1'b1, "R10 reload after release");
        do_read(16'hBEEF, 16'h6C6C, 1'b1, 1'b1, 1'b0, -1, 1'b0, 2*W);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule